// File: doc/BRIEF.md
# Physical Memory Attribute Checker

This block classifies each memory access that a processor pipeline is about to issue (an instruction fetch, a data load or a data store, optionally marked as atomic) against a fixed table of address regions. Each region spans a half-open range of word addresses. It carries three attributes: main memory or I/O, instruction execution allowed, and atomic operations allowed. The block reports the attributes that apply to the address, whether the access must be refused, and the RISC-V exception code that the trap logic should raise.

Alignment is enforced only where the memory type requires it. A misaligned data access to I/O is refused with an access-fault code and not with a misaligned code. A misaligned access to main memory passes, because splitting it is the job of the load/store unit. Addresses that fall in no region are treated as I/O. If the table is configured with no regions at all, the whole address space is main memory, executable and atomic-capable.

The verdict is registered. It appears on the outputs one clock after the access is presented, so the checker can sit between two pipeline stages.

Top module: `pma_checker`

## Requirements
- R1: An access falls in region i when lo_word <= addr[33:2] < hi_word (upper bound exclusive). The outputs then report that region's main, execute and atomic attributes.
- R2: When several configured regions contain the address, the region with the lowest index supplies the attributes.
- R3: With at least one region configured, an address in no region reports main=0, execute=0 and atomic=0. It is then checked as I/O.
- R4: The verdict and attributes for an access appear on the outputs exactly one clock after it is presented. While rst_n is low, every output is 0.
- R5: A fetch (kind 0) faults with cause 1 when the region is I/O or not executable, whatever its alignment. A fetch from executable main memory never faults, even when misaligned.
- R6: A load (kind 1) that is not naturally aligned faults with cause 5 when the region is I/O. A misaligned load to main memory, or an aligned load to I/O, does not fault.
- R7: A store (kind 2) that is not naturally aligned faults with cause 7 when the region is I/O.
- R8: Natural alignment by size code: byte (0) is aligned at any offset. Halfword (1) is aligned at addr[1:0] = 00 or 10; offsets 01 and 11 are misaligned. Word (2) is aligned only at offset 00.
- R9: An atomic load or store faults with cause 5 or 7 respectively when its region is not atomic-capable. With regions configured, this includes an address in no region.
- R10: With zero regions configured, every access reports main=1, execute=1 and atomic=1, and no access ever faults. The region table then holds one unused slot instead of an empty or reversed range.
- R11: When no fault is reported, the cause output is 0. When a fault is reported, the cause is 1, 5 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 34 | Physical byte address of the access |
| kind_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| amo_i | input | 1 | Access is part of an atomic operation |
| fault_o | output | 1 | Access must be refused |
| cause_o | output | 6 | Exception code to raise (0 when no fault) |
| is_main_o | output | 1 | Address is main memory (0 means I/O) |
| exec_ok_o | output | 1 | Instruction fetch allowed at the address |
| amo_ok_o | output | 1 | Atomic operations allowed at the address |

## Verification
On every cycle, the assertions check how the cause code follows from the access kind. They also check that a fetch from executable main memory and a plain byte data access never fault, and that a zero-region instance never faults and always reports full attributes. Only the bench scenarios can show that the right region was chosen. These cover the exclusive upper bound, overlap priority, the unmatched-address default, and the exact alignment offsets that fault in I/O but pass in main memory. The bench compares a behavioural model against both a three-region instance and a zero-region instance.

// File: rtl/pma_chk_pkg.sv
package pma_chk_pkg;

    localparam int unsigned ADDR_W  = 34;
    localparam int unsigned WORD_W  = ADDR_W - 2;
    localparam int unsigned CAUSE_W = 6;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 6'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 6'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 6'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE = 6'd7;

    typedef struct packed {
        logic [WORD_W-1:0] lo_word;
        logic [WORD_W-1:0] hi_word;
        logic              is_main;
        logic              exec_ok;
        logic              amo_ok;
    } region_t;

    localparam region_t REGION_VOID = '{lo_word: '0, hi_word: '0,
                                        is_main: 1'b0, exec_ok: 1'b0, amo_ok: 1'b0};

    typedef struct packed {
        logic is_main;
        logic exec_ok;
        logic amo_ok;
    } attr_t;

    typedef struct packed {
        logic               fault;
        logic [CAUSE_W-1:0] cause;
        attr_t              attr;
    } verdict_t;

endpackage

// File: rtl/pma_region_match.sv
module pma_region_match
    import pma_chk_pkg::*;
#(
    parameter int unsigned TBL_N    = 1,
    parameter int unsigned ACTIVE_N = 1,
    parameter region_t     CFG [TBL_N] = '{default: REGION_VOID}
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [TBL_N-1:0]  hit_o
);

    // One comparator pair per table slot; slots beyond the active count never hit.
    for (genvar i = 0; i < TBL_N; i++) begin : g_slot
        if (i < ACTIVE_N) begin : g_live
            assign hit_o[i] = (word_i >= CFG[i].lo_word) && (word_i < CFG[i].hi_word);
        end else begin : g_idle
            assign hit_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/pma_prio_select.sv
module pma_prio_select
    import pma_chk_pkg::*;
#(
    parameter int unsigned TBL_N = 1,
    parameter region_t     CFG [TBL_N] = '{default: REGION_VOID}
) (
    input  logic [TBL_N-1:0] hit_i,
    output logic             matched_o,
    output attr_t            attr_o
);

    // Walk from the top slot down so the lowest hitting index is the last writer.
    always_comb begin
        matched_o = 1'b0;
        attr_o    = '0;
        for (int i = TBL_N - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                matched_o      = 1'b1;
                attr_o.is_main = CFG[i].is_main;
                attr_o.exec_ok = CFG[i].exec_ok;
                attr_o.amo_ok  = CFG[i].amo_ok;
            end
        end
    end

endmodule

// File: rtl/pma_fault_eval.sv
module pma_fault_eval
    import pma_chk_pkg::*;
#(
    parameter bit ENFORCE = 1'b1
) (
    input  logic [1:0]         kind_i,
    input  logic [1:0]         size_i,
    input  logic [1:0]         offset_i,
    input  logic               amo_i,
    input  attr_t              attr_i,
    output logic               fault_o,
    output logic [CAUSE_W-1:0] cause_o
);

    logic misaligned;
    logic io_misaligned;
    logic amo_refused;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = offset_i[0];
            default: misaligned = (offset_i != 2'b00);
        endcase
    end

    assign io_misaligned = !attr_i.is_main && misaligned;
    assign amo_refused   = amo_i && !attr_i.amo_ok;

    always_comb begin
        fault_o = 1'b0;
        cause_o = CAUSE_NONE;
        if (ENFORCE) begin
            unique case (kind_i)
                ACC_FETCH: begin
                    // Execution permission outranks any misalignment of the fetch.
                    if (!attr_i.exec_ok || !attr_i.is_main) begin
                        fault_o = 1'b1;
                        cause_o = CAUSE_FETCH;
                    end
                end
                ACC_LOAD: begin
                    if (io_misaligned || amo_refused) begin
                        fault_o = 1'b1;
                        cause_o = CAUSE_LOAD;
                    end
                end
                ACC_STORE: begin
                    if (io_misaligned || amo_refused) begin
                        fault_o = 1'b1;
                        cause_o = CAUSE_STORE;
                    end
                end
                default: begin
                    fault_o = 1'b0;
                    cause_o = CAUSE_NONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pma_checker.sv
module pma_checker
    import pma_chk_pkg::*;
#(
    parameter  int unsigned NUM_REGIONS = 1,
    localparam int unsigned TBL_N       = (NUM_REGIONS == 0) ? 1 : NUM_REGIONS,
    parameter  region_t     REGION_CFG [TBL_N] = '{default: REGION_VOID}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [1:0]         kind_i,
    input  logic [1:0]         size_i,
    input  logic               amo_i,
    output logic               fault_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               is_main_o,
    output logic               exec_ok_o,
    output logic               amo_ok_o
);

    localparam bit HAS_REGIONS = (NUM_REGIONS != 0);

    logic [TBL_N-1:0]   hit;
    logic               matched;
    attr_t              sel_attr;
    attr_t              eff_attr;
    logic               fault_c;
    logic [CAUSE_W-1:0] cause_c;
    verdict_t           verdict_d;
    verdict_t           verdict_q;

    pma_region_match #(
        .TBL_N    (TBL_N),
        .ACTIVE_N (NUM_REGIONS),
        .CFG      (REGION_CFG)
    ) u_match (
        .word_i (addr_i[ADDR_W-1:2]),
        .hit_o  (hit)
    );

    pma_prio_select #(
        .TBL_N (TBL_N),
        .CFG   (REGION_CFG)
    ) u_select (
        .hit_i     (hit),
        .matched_o (matched),
        .attr_o    (sel_attr)
    );

    // Attribute fallback: an empty table grants everything, a miss in a
    // populated table falls back to non-executable, non-atomic I/O.
    if (HAS_REGIONS) begin : g_table
        assign eff_attr = matched ? sel_attr : attr_t'('0);
    end else begin : g_open
        assign eff_attr = '{is_main: 1'b1, exec_ok: 1'b1, amo_ok: 1'b1};
    end

    pma_fault_eval #(
        .ENFORCE (HAS_REGIONS)
    ) u_eval (
        .kind_i   (kind_i),
        .size_i   (size_i),
        .offset_i (addr_i[1:0]),
        .amo_i    (amo_i),
        .attr_i   (eff_attr),
        .fault_o  (fault_c),
        .cause_o  (cause_c)
    );

    always_comb begin
        verdict_d       = verdict_q;
        verdict_d.fault = fault_c;
        verdict_d.cause = cause_c;
        verdict_d.attr  = eff_attr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign fault_o   = verdict_q.fault;
    assign cause_o   = verdict_q.cause;
    assign is_main_o = verdict_q.attr.is_main;
    assign exec_ok_o = verdict_q.attr.exec_ok;
    assign amo_ok_o  = verdict_q.attr.amo_ok;

endmodule

// File: rtl/pma_checker_sva.sv
module pma_checker_sva #(
    parameter int unsigned NUM_REGIONS = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] kind_i,
    input logic [1:0] size_i,
    input logic       amo_i,
    input logic       fault_o,
    input logic [5:0] cause_o,
    input logic       is_main_o,
    input logic       exec_ok_o,
    input logic       amo_ok_o
);

    // Set once a full cycle out of reset has passed, so $past sees driven inputs.
    logic primed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    p_quiet_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> (cause_o == 6'd0));

    p_known_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (cause_o == 6'd1 || cause_o == 6'd5 || cause_o == 6'd7));

    p_fetch_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(kind_i) == 2'd0 && fault_o) |-> (cause_o == 6'd1));

    p_fetch_allowed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(kind_i) == 2'd0 && is_main_o && exec_ok_o) |-> !fault_o);

    p_load_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(kind_i) == 2'd1 && fault_o) |-> (cause_o == 6'd5));

    p_store_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(kind_i) == 2'd2 && fault_o) |-> (cause_o == 6'd7));

    p_byte_never_faults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(size_i) == 2'd0 && !$past(amo_i) && $past(kind_i) != 2'd0)
            |-> !fault_o);

    p_amo_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(kind_i) != 2'd0 && $past(size_i) == 2'd2 && amo_ok_o && is_main_o)
            |-> !fault_o);

    if (NUM_REGIONS == 0) begin : g_open_chk
        p_open_space_r10: assert property (@(posedge clk) disable iff (!rst_n)
            primed_q |-> (!fault_o && is_main_o && exec_ok_o && amo_ok_o));
    end

endmodule

bind pma_checker pma_checker_sva #(.NUM_REGIONS(NUM_REGIONS)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind_i    (kind_i),
    .size_i    (size_i),
    .amo_i     (amo_i),
    .fault_o   (fault_o),
    .cause_o   (cause_o),
    .is_main_o (is_main_o),
    .exec_ok_o (exec_ok_o),
    .amo_ok_o  (amo_ok_o)
);

// File: tb/pma_checker_bench.sv
module pma_checker_bench;
    import pma_chk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [33:0] addr = '0;
    logic [1:0]  kind = '0;
    logic [1:0]  size = '0;
    logic        amo = 1'b0;

    logic       f_a, m_a, x_a, a_a;
    logic [5:0] c_a;
    logic       f_z, m_z, x_z, a_z;
    logic [5:0] c_z;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    localparam region_t BENCH_CFG [3] = '{
        '{32'h0000_0000, 32'h0000_4000, 1'b1, 1'b1, 1'b1},
        '{32'h0000_2000, 32'h0000_8000, 1'b0, 1'b0, 1'b0},
        '{32'h0000_8000, 32'h0001_0000, 1'b1, 1'b0, 1'b0}
    };

    pma_checker #(.NUM_REGIONS(3), .REGION_CFG(BENCH_CFG)) u_pma_checker (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .kind_i(kind), .size_i(size), .amo_i(amo),
        .fault_o(f_a), .cause_o(c_a), .is_main_o(m_a), .exec_ok_o(x_a), .amo_ok_o(a_a)
    );

    pma_checker #(.NUM_REGIONS(0)) u_pma_checker_zero (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .kind_i(kind), .size_i(size), .amo_i(amo),
        .fault_o(f_z), .cause_o(c_z), .is_main_o(m_z), .exec_ok_o(x_z), .amo_ok_o(a_z)
    );

    // Behavioural reference: byte-address ranges, first listed range wins.
    typedef struct { bit fault; int cause; bit m; bit x; bit a; } exp_t;

    longint ref_lo [3] = '{64'h0, 64'h8000, 64'h20000};
    longint ref_hi [3] = '{64'h10000, 64'h20000, 64'h40000};
    bit     ref_m  [3] = '{1, 0, 1};
    bit     ref_x  [3] = '{1, 0, 0};
    bit     ref_a  [3] = '{1, 0, 0};

    function automatic exp_t model(bit open, logic [33:0] ad, int k, int s, bit at);
        exp_t e = '{0, 0, 0, 0, 0};
        bit found = 0;
        bit mis;
        longint b = longint'(ad) & ~longint'(3);
        int off = int'(ad[1:0]);
        if (open) return '{0, 0, 1, 1, 1};
        for (int i = 0; i < 3; i++)
            if (!found && b >= ref_lo[i] && b < ref_hi[i]) begin
                found = 1; e.m = ref_m[i]; e.x = ref_x[i]; e.a = ref_a[i];
            end
        mis = (s == 2) ? (off != 0) : (s == 1) ? (off % 2 == 1) : 0;
        if (k == 0 && !(e.m && e.x)) begin e.fault = 1; e.cause = 1; end
        if (k == 1 && ((!e.m && mis) || (at && !e.a))) begin e.fault = 1; e.cause = 5; end
        if (k == 2 && ((!e.m && mis) || (at && !e.a))) begin e.fault = 1; e.cause = 7; end
        return e;
    endfunction

    exp_t  q_a [$];
    exp_t  q_z [$];
    string q_t [$];

    task automatic cmp(string tag, logic f, logic [5:0] c, logic m, logic x, logic a, exp_t e);
        checks++;
        if ({f, c, m, x, a} !== {e.fault, 6'(e.cause), e.m, e.x, e.a}) begin
            errors++;
            $display("FAIL %s: got fault=%0b cause=%0d main=%0b exec=%0b amo=%0b, exp fault=%0b cause=%0d main=%0b exec=%0b amo=%0b",
                     tag, f, c, m, x, a, e.fault, e.cause, e.m, e.x, e.a);
        end
    endtask

    // One step: check last cycle's access, then present the next one.
    task automatic step(logic [33:0] ad, int k, int s, bit at, string tag);
        @(negedge clk);
        if (q_t.size() != 0) begin
            string t = q_t.pop_front();
            cmp(t, f_a, c_a, m_a, x_a, a_a, q_a.pop_front());
            cmp({t, "/R10"}, f_z, c_z, m_z, x_z, a_z, q_z.pop_front());
        end
        addr = ad; kind = 2'(k); size = 2'(s); amo = at;
        q_a.push_back(model(0, ad, k, s, at));
        q_z.push_back(model(1, ad, k, s, at));
        q_t.push_back(tag);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        addr = 34'h1_0001; kind = 2'd1; size = 2'd2;
        @(negedge clk);
        cmp("R4 reset", f_a, c_a, m_a, x_a, a_a, '{0, 0, 0, 0, 0});
        cmp("R4 reset zero", f_z, c_z, m_z, x_z, a_z, '{0, 0, 0, 0, 0});
        rst_n = 1'b1;

        step(34'h0_0100, 0, 2, 0, "R1 fetch main");
        step(34'h0_0102, 0, 1, 0, "R5 misaligned fetch main");
        step(34'h0_FFFC, 0, 2, 0, "R1 last word of region 0");
        step(34'h1_0000, 0, 2, 0, "R5 fetch from I/O");
        step(34'h1_0002, 0, 2, 0, "R5 fetch I/O misaligned priority");
        step(34'h2_0000, 0, 2, 0, "R5 fetch non-exec main");
        step(34'h0_8000, 0, 2, 0, "R2 overlap lowest wins");
        step(34'h0_8001, 1, 2, 0, "R2 overlap misaligned load main");
        step(34'h1_0001, 1, 2, 0, "R6 word load I/O offset 01");
        step(34'h1_0000, 1, 2, 0, "R6 aligned load I/O");
        step(34'h0_0101, 1, 2, 0, "R6 misaligned load main");
        step(34'h1_0001, 1, 1, 0, "R8 half offset 01 I/O");
        step(34'h1_0002, 1, 1, 0, "R8 half offset 10 I/O");
        step(34'h1_0003, 1, 1, 0, "R8 half offset 11 I/O");
        step(34'h1_0003, 1, 0, 0, "R8 byte any offset I/O");
        step(34'h1_0002, 2, 2, 0, "R7 word store I/O offset 10");
        step(34'h1_0001, 2, 1, 0, "R7 half store I/O offset 01");
        step(34'h1_0004, 2, 2, 0, "R7 aligned store I/O");
        step(34'h0_0100, 1, 2, 1, "R9 atomic load allowed");
        step(34'h2_0000, 2, 2, 1, "R9 atomic store refused main");
        step(34'h1_0000, 1, 2, 1, "R9 atomic load refused I/O");
        step(34'h1_FFFD, 1, 1, 0, "R1 half below region 2 bound");
        step(34'h2_0001, 1, 1, 0, "R1 half in main region 2");
        step(34'h1_0000_0000, 1, 2, 0, "R3 unmatched aligned load");
        step(34'h1_0000_0002, 1, 2, 0, "R3 unmatched misaligned load");
        step(34'h1_0000_0000, 0, 2, 0, "R3 unmatched fetch");
        step(34'h1_0000_0000, 2, 2, 1, "R3 unmatched atomic store");
        step(34'h3_FFFF_FFFD, 1, 1, 0, "R3 top address half");
        step(34'h3_FFFF_FFFC, 2, 2, 0, "R11 top address aligned store");

        for (int n = 0; n < 400; n++) begin
            logic [33:0] ad;
            if (n % 7 == 0) ad = {2'($urandom_range(0, 3)), 32'($urandom)};
            else            ad = 34'($urandom_range(0, 32'h4_7FFF));
            step(ad, $urandom_range(0, 2), $urandom_range(0, 2), 1'($urandom_range(0, 1)),
                 "R11 random mix");
        end
        step(34'h0, 0, 0, 0, "R4 flush");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule